// File: doc/BRIEF.md
# Native Memory User-Interface Emulator

This block stands in for the user-side port of a DDR memory controller, so that a traffic generator or test sequencer can be verified without a real controller, PHY or DRAM model. Each command moves one 128-bit word, which is one burst of eight beats on a 16-bit device. The storage is an on-chip word array indexed by the word part of the address. Commands and addresses arrive through an enable/ready handshake. Write data arrives through a separate enable/ready handshake that has its own queue. Read data returns in command order, after a variable delay, marked by a one-cycle valid strobe.

After reset, the emulator holds its ready outputs low until a calibration-done output rises after a set delay. A seeded LFSR makes command-ready stall for stretches of up to 31 cycles and picks each read's return delay. The behaviour is therefore irregular but repeatable from run to run. A sticky error flag reports write commands whose data arrives too late, and data beats presented without the burst-end marker.

Top module: `memif_emu`

## Requirements
- R1: While reset is high, `cmd_rdy`, `wr_rdy`, `rd_valid`, `cal_done` and `proto_err` are low. `cal_done` rises exactly CAL_DELAY clock edges after the first edge that samples reset low, and it then stays high.
- R2: While `cal_done` is low, `cmd_rdy` and `wr_rdy` are low, so no command and no data beat is taken.
- R3: A command is taken only in a cycle where `cmd_en` and `cmd_rdy` are both high. The 3-bit `cmd_op` value 0 is a write and 1 is a read. Any other value is taken but has no effect: no storage change and no return.
- R4: A data beat is taken only in a cycle where `wr_en` and `wr_rdy` are both high. Up to WQ_DEPTH beats (default 4) may queue, and `wr_rdy` is low while the queue is full. Write commands and data beats pair first-in first-out. Data may come before its command, in the same cycle, or one or two cycles after the command's cycle.
- R5: `proto_err` is sticky until reset. It sets when the oldest write command is still without data three cycles after the cycle it was taken in, or when a beat is taken with `wr_end` low.
- R6: The word index is `cmd_addr[3 +: log2(MEM_WORDS)]`. Address bits 2:0 are ignored, so consecutive words lie 8 apart.
- R7: Each read returns exactly one pulse of `rd_valid`, in command order. `rd_data` holds the word most recently paired to that index before the return.
- R8: `rd_valid` for a read appears L cycles after the cycle in which the read was taken, with 2 ≤ L ≤ 16. The only exception is that a return may be later than 16 cycles when it directly follows the previous return, because returns keep command order.
- R9: `cmd_rdy` is low while the return queue holds RQ_DEPTH reads (default 8) or the write-command queue holds WQ_DEPTH entries.
- R10: With STALL_EN set, `cmd_rdy` drops for LFSR-chosen stretches even when all queues are empty. During such a stall `wr_rdy` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_en | input | 1 | Command valid |
| cmd_op | input | 3 | Command code: 0 write, 1 read |
| cmd_addr | input | ADDR_W | Command address (word = bits above bit 2) |
| cmd_rdy | output | 1 | Command accepted this cycle when high with cmd_en |
| wr_en | input | 1 | Write data beat valid |
| wr_end | input | 1 | Burst-end marker, must accompany every beat |
| wr_data | input | DATA_W | Write data word |
| wr_rdy | output | 1 | Data beat accepted when high with wr_en |
| rd_data | output | DATA_W | Returned read word |
| rd_valid | output | 1 | One-cycle strobe marking rd_data valid |
| cal_done | output | 1 | Startup delay elapsed, interface usable |
| proto_err | output | 1 | Sticky write-pairing or burst-end error |

## Verification
The bench writes every word of a small array while cycling through four data timings: data leading the command, data in the same cycle, data one cycle behind and data two cycles behind. A storage or pairing mistake in any one timing then shows up as a wrong word in a specific quarter of the addresses. A back-to-back read sweep with non-zero low address bits tells apart correct word indexing, ordering and latency bounds from an emulator that indexes by byte or reorders returns. Separate patterns fill the data queue with no commands, send an unsupported opcode, and leave write commands without data. These three isolate the queue-full behaviour, the no-effect rule and the late-data error from the normal path.

// File: rtl/memif_emu.sv
module memif_emu #(
  parameter int unsigned DATA_W    = 128,
  parameter int unsigned ADDR_W    = 28,
  parameter int unsigned MEM_WORDS = 64,
  parameter int unsigned CAL_DELAY = 200,
  parameter int unsigned RQ_DEPTH  = 8,
  parameter int unsigned WQ_DEPTH  = 4,
  parameter bit          STALL_EN  = 1'b1,
  parameter bit          LAT_RAND  = 1'b1,
  parameter int unsigned FIX_LAT   = 4,
  parameter logic [15:0] SEED      = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_en,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_rdy,
  input  logic              wr_en,
  input  logic              wr_end,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_rdy,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              cal_done,
  output logic              proto_err
);
  localparam int IDX_W = $clog2(MEM_WORDS);
  localparam int RQ_AW = $clog2(RQ_DEPTH);
  localparam int WQ_AW = $clog2(WQ_DEPTH);
  localparam int CAL_W = $clog2(CAL_DELAY + 1);
  localparam logic [RQ_AW:0] RQ_FULL = (RQ_AW+1)'(RQ_DEPTH);
  localparam logic [WQ_AW:0] WQ_FULL = (WQ_AW+1)'(WQ_DEPTH);

  logic [DATA_W-1:0] mem [MEM_WORDS];

  logic [CAL_W-1:0] cal_cnt;
  logic [15:0]      lfsr;
  logic [4:0]       stall_cnt;
  logic [3:0]       pick;
  logic [7:0]       now;

  logic [DATA_W-1:0] wdq [WQ_DEPTH];
  logic [WQ_AW-1:0]  wdq_wp, wdq_rp;
  logic [WQ_AW:0]    wdq_cnt;

  logic [IDX_W-1:0]  wcq [WQ_DEPTH];
  logic [WQ_AW-1:0]  wcq_wp, wcq_rp;
  logic [WQ_AW:0]    wcq_cnt;
  logic [1:0]        age;

  logic [IDX_W-1:0]  rq_idx [RQ_DEPTH];
  logic [7:0]        rq_due [RQ_DEPTH];
  logic [RQ_AW-1:0]  rq_wp, rq_rp;
  logic [RQ_AW:0]    rq_cnt;

  logic [IDX_W-1:0] cmd_idx;
  logic [7:0]       head_diff;
  logic cmd_take, wr_take, pair, rq_pop, push_wr, push_rd;

  assign cal_done  = (cal_cnt == CAL_W'(CAL_DELAY));
  assign cmd_rdy   = cal_done && (stall_cnt == 5'd0) && (rq_cnt != RQ_FULL) && (wcq_cnt != WQ_FULL);
  assign wr_rdy    = cal_done && (wdq_cnt != WQ_FULL);
  assign cmd_take  = cmd_en && cmd_rdy;
  assign wr_take   = wr_en && wr_rdy;
  assign push_wr   = cmd_take && (cmd_op == 3'd0);
  assign push_rd   = cmd_take && (cmd_op == 3'd1);
  assign cmd_idx   = cmd_addr[3 +: IDX_W];
  assign pair      = (wcq_cnt != '0) && (wdq_cnt != '0);
  assign head_diff = now - rq_due[rq_rp];
  assign rq_pop    = (rq_cnt != '0) && !head_diff[7];

  wire unused_bits = ^{cmd_addr, lfsr};

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_cnt <= '0;
      lfsr    <= SEED;
    end else begin
      if (!cal_done) cal_cnt <= cal_cnt + 1'b1;
      lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
    end
  end

  generate
    if (STALL_EN) begin : g_stall
      always_ff @(posedge clk) begin
        if (rst) stall_cnt <= '0;
        else if (stall_cnt != 5'd0) stall_cnt <= stall_cnt - 5'd1;
        else if (cal_done && lfsr[4:0] == 5'd0) stall_cnt <= lfsr[9:5] | 5'd4;
      end
    end else begin : g_nostall
      assign stall_cnt = '0;
    end
    if (LAT_RAND) begin : g_lat_rand
      assign pick = (lfsr[11:8] == 4'd0) ? 4'd1 : lfsr[11:8];
    end else begin : g_lat_fix
      assign pick = 4'(FIX_LAT - 1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      now <= '0;
      wdq_wp <= '0; wdq_rp <= '0; wdq_cnt <= '0;
      wcq_wp <= '0; wcq_rp <= '0; wcq_cnt <= '0;
      rq_wp  <= '0; rq_rp  <= '0; rq_cnt  <= '0;
      age <= '0;
      proto_err <= 1'b0;
      rd_valid  <= 1'b0;
    end else begin
      now <= now + 8'd1;
      if (wr_take) wdq_wp <= wdq_wp + 1'b1;
      if (push_wr) wcq_wp <= wcq_wp + 1'b1;
      if (pair) begin
        wdq_rp <= wdq_rp + 1'b1;
        wcq_rp <= wcq_rp + 1'b1;
      end
      wdq_cnt <= wdq_cnt + (WQ_AW+1)'(wr_take) - (WQ_AW+1)'(pair);
      wcq_cnt <= wcq_cnt + (WQ_AW+1)'(push_wr) - (WQ_AW+1)'(pair);

      if (pair || wcq_cnt == '0) age <= '0;
      else if (wdq_cnt == '0 && age != 2'd3) age <= age + 2'd1;

      if ((wcq_cnt != '0 && wdq_cnt == '0 && age == 2'd2) || (wr_take && !wr_end))
        proto_err <= 1'b1;

      if (push_rd) rq_wp <= rq_wp + 1'b1;
      if (rq_pop)  rq_rp <= rq_rp + 1'b1;
      rq_cnt   <= rq_cnt + (RQ_AW+1)'(push_rd) - (RQ_AW+1)'(rq_pop);
      rd_valid <= rq_pop;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_take) wdq[wdq_wp] <= wr_data;
    if (push_wr) wcq[wcq_wp] <= cmd_idx;
    if (pair)    mem[wcq[wcq_rp]] <= wdq[wdq_rp];
    if (push_rd) begin
      rq_idx[rq_wp] <= cmd_idx;
      rq_due[rq_wp] <= now + 8'(pick);
    end
    if (rq_pop) rd_data <= mem[rq_idx[rq_rp]];
  end

  AST_CAL_HOLD:      assert property (@(posedge clk) disable iff (rst) cal_done |=> cal_done); // R1
  AST_IDLE_PRECAL:   assert property (@(posedge clk) disable iff (rst) !cal_done |-> (!cmd_rdy && !wr_rdy)); // R2
  AST_ERR_STICKY:    assert property (@(posedge clk) disable iff (rst) proto_err |=> proto_err); // R5
  AST_WDQ_BOUND:     assert property (@(posedge clk) disable iff (rst) wdq_cnt <= WQ_FULL); // R4
  AST_RQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) rq_cnt <= RQ_FULL); // R9
  AST_WCQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) wcq_cnt <= WQ_FULL); // R9
  AST_RET_FROM_QUEUE: assert property (@(posedge clk) disable iff (rst) rd_valid |-> $past(rq_cnt) != '0); // R7
endmodule

// File: tb/memif_emu_test.sv
`timescale 1ns/100ps
module memif_emu_test;
  localparam int CALD = 12;
  localparam int WORDS = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_en = 1'b0, wr_en = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [27:0] cmd_addr = '0;
  logic [127:0] wr_data = '0;
  logic wr_end;
  logic cmd_rdy, wr_rdy, rd_valid, cal_done, proto_err;
  logic [127:0] rd_data;

  assign wr_end = wr_en;
  always #2.5 clk = ~clk;

  memif_emu #(.MEM_WORDS(WORDS), .CAL_DELAY(CALD)) uut (
    .clk(clk), .rst(rst), .cmd_en(cmd_en), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_rdy(cmd_rdy), .wr_en(wr_en), .wr_end(wr_end), .wr_data(wr_data),
    .wr_rdy(wr_rdy), .rd_data(rd_data), .rd_valid(rd_valid),
    .cal_done(cal_done), .proto_err(proto_err));

  int total = 0, bad = 0, cyc = 0, last_rv = -10;
  logic [127:0] eq_data [64];
  int eq_cyc [64];
  int eq_wr = 0, eq_rd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] pat(input int i);
    return {32'hC0DE0000 + 32'(i), ~32'(i), 32'(i * i + 7), 32'(i) ^ 32'h5A5A1234};
  endfunction

  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (eq_rd == eq_wr) check(1'b0, "R3 unexpected rd_valid", 1, 0);
      else begin
        check(rd_data == eq_data[eq_rd], "R7 read data/order", rd_data, eq_data[eq_rd]);
        check((cyc - eq_cyc[eq_rd]) >= 2, "R8 latency min", cyc - eq_cyc[eq_rd], 2);
        check((cyc - eq_cyc[eq_rd]) <= 16 || last_rv == cyc - 1, "R8 latency max",
              cyc - eq_cyc[eq_rd], 16);
        eq_rd++;
      end
      last_rv = cyc;
    end
  end

  task automatic do_cmd(input logic [2:0] op, input logic [27:0] a, output int c);
    cmd_op = op; cmd_addr = a; cmd_en = 1'b1;
    while (!cmd_rdy) @(negedge clk);
    c = cyc;
    @(posedge clk);
    @(negedge clk);
    cmd_en = 1'b0;
  endtask

  task automatic rd_word(input logic [27:0] a, input logic [127:0] expd);
    int c;
    do_cmd(3'd1, a, c);
    eq_data[eq_wr] = expd; eq_cyc[eq_wr] = c; eq_wr++;
  endtask

  // mode 0: data leads, 1: same cycle, 2: data one cycle late, 3: two cycles late
  task automatic wr_pair(input logic [27:0] a, input logic [127:0] d, input int mode);
    bit cd = 0, dd = 0, ca, da;
    int k = 0, kc = 0;
    cmd_op = 3'd0; cmd_addr = a; wr_data = d;
    while (!(cd && dd)) begin
      cmd_en = !cd && (mode != 0 || dd);
      wr_en  = !dd && (mode <= 1 || (cd && k >= kc + mode - 1));
      ca = cmd_en && cmd_rdy;
      da = wr_en && wr_rdy;
      @(posedge clk);
      if (ca) begin cd = 1; kc = k; end
      if (da) dd = 1;
      @(negedge clk);
      k++;
    end
    cmd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "R1 watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, stalls, wbad, c;
    bit pre_bad;
    repeat (4) @(negedge clk);
    check(!cmd_rdy && !wr_rdy && !rd_valid && !cal_done && !proto_err, "R1 reset outputs",
          {cmd_rdy, wr_rdy, rd_valid, cal_done, proto_err}, 0);
    rst = 1'b0;
    n = 0; pre_bad = 0;
    while (!cal_done && n < 100) begin
      @(negedge clk);
      n++;
      if (!cal_done && (cmd_rdy || wr_rdy)) pre_bad = 1;
    end
    check(n == CALD, "R1 cal_done delay", n, CALD);
    check(!pre_bad, "R2 ready before calibration", pre_bad, 0);

    stalls = 0; wbad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      check(cal_done, "R1 cal_done holds", cal_done, 1);
      if (!cmd_rdy) begin
        stalls++;
        if (!wr_rdy) wbad++;
      end
    end
    check(stalls > 0, "R10 stalls seen", stalls, 1);
    check(wbad == 0, "R10 wr_rdy during stall", wbad, 0);

    for (int i = 0; i < WORDS; i++) wr_pair(28'(i * 8), pat(i), i % 4);
    idle(10);
    check(!proto_err, "R4 legal data timings no error", proto_err, 0);

    for (int i = 0; i < WORDS; i++) rd_word(28'(i * 8 + (i % 8)), pat(i)); // R6 low bits
    idle(40);

    do_cmd(3'd3, 28'd16, c);
    do_cmd(3'd5, 28'd24, c);
    rd_word(28'd16, pat(2));   // R3 word 2 unchanged
    rd_word(28'd24, pat(3));
    idle(40);
    check(eq_rd == eq_wr, "R7 all reads returned", eq_rd, eq_wr);

    for (int i = 0; i < 4; i++) begin
      wr_data = pat(100 + i); wr_en = 1'b1;
      while (!wr_rdy) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
    end
    check(!wr_rdy, "R4 data queue full", wr_rdy, 0);
    for (int i = 0; i < 4; i++) do_cmd(3'd0, 28'(i * 8), c);
    idle(5);
    check(wr_rdy, "R4 data queue drained", wr_rdy, 1);
    for (int i = 0; i < 4; i++) rd_word(28'(i * 8), pat(100 + i));
    idle(40);
    check(eq_rd == eq_wr, "R7 queued writes returned", eq_rd, eq_wr);
    check(!proto_err, "R5 no error before late data", proto_err, 0);

    do_cmd(3'd0, 28'd40, c);
    idle(2);
    check(!proto_err, "R5 not yet late", proto_err, 0);
    idle(2);
    check(proto_err, "R5 late data flagged", proto_err, 1);
    for (int i = 0; i < 3; i++) do_cmd(3'd0, 28'(48 + i * 8), c);
    @(negedge clk);
    check(!cmd_rdy, "R9 write-command queue full blocks", cmd_rdy, 0);
    idle(10);
    check(proto_err, "R5 error sticky", proto_err, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule